// File: doc/BRIEF.md
# Address-Space-Tagged Fully Associative TLB

This block caches virtual-to-physical page translations in a fully associative array with a parameterised number of entries (typically 48 for an instruction path or 64 for a data path). Each entry stores a virtual page number tag, a physical page number, an address-space number, a global flag, and a permission word: per-mode read enables, per-mode write enables, a fault-on-read bit and a fault-on-write bit. Walking page tables and judging permissions belong to the surrounding logic. This block only stores entries and returns the permission word of the entry that hits.

A lookup is combinational and completes in the cycle it is presented. New entries arrive on a valid/ready insertion channel and always land at a round-robin replacement pointer. The insertion channel applies back-pressure in one case only: `ins_ready` is low in any cycle in which a flush pin is high. The producer holds `ins_valid` and the payload until it sees a cycle with both valid and ready high. Three flush pins do different jobs. One clears everything. One drops all entries that are not global. One drops the entries that would hit for a given page and address space. A separate read port always shows the entry under the replacement pointer, and it can step the pointer forward without writing.

Top module: `tlb_asn_cam`

## Requirements
- R1: With `lk_valid` high, `lk_hit` is high in the same cycle exactly when some valid entry has a tag equal to `lk_vpn` and either has its global flag set or has an address-space number equal to `lk_asn`. `lk_ppn` and `lk_perm` then carry that entry's fields. With `lk_valid` low, `lk_hit` is low.
- R2: When several entries hit, the lowest-indexed one is reported, and `lk_idx` gives its index.
- R3: An insertion is accepted when `ins_valid` and `ins_ready` are both high at a rising edge. It writes the entry at the replacement pointer, replacing whatever that slot held, and the new entry can be looked up from the next cycle.
- R4: Each accepted insertion advances the replacement pointer by one. After index ENTRIES-1 the pointer wraps to zero.
- R5: `flush_all` invalidates every entry and sets the replacement pointer to zero in the next cycle.
- R6: `flush_proc` invalidates every entry whose global flag is clear and leaves global entries valid.
- R7: `flush_addr` invalidates every entry that a lookup of `fl_vpn`/`fl_asn` would hit, including global entries with that tag. Entries with that tag, a different address-space number and a clear global flag stay valid.
- R8: `rd_ptr`, `rd_vld`, `rd_vpn`, `rd_ppn`, `rd_asn`, `rd_glb` and `rd_perm` show the slot at the replacement pointer. `rd_adv` advances the pointer by one (with wrap). If `rd_adv` and an accepted insertion fall in the same cycle, the pointer advances by one in total.
- R9: When more than one flush pin is high, `flush_all` takes priority over `flush_proc`, which takes priority over `flush_addr`. While any flush pin is high, `ins_ready` is low and no insertion takes place.
- R10: A lookup made in the same cycle as a flush sees the entries as they were before that flush.
- R11: After reset, no entry is valid and the replacement pointer is zero.
- R12: `lk_perm`, `ins_perm` and `rd_perm` share one layout. Bits [MODES-1:0] are the read enables, bits [2*MODES-1:MODES] are the write enables, bit 2*MODES is fault-on-read and bit 2*MODES+1 is fault-on-write. The block stores this word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lk_valid | input | 1 | Lookup request present |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| lk_asn | input | ASN_W | Lookup address-space number |
| lk_hit | output | 1 | Lookup hit |
| lk_idx | output | IDX_W | Index of the reported entry |
| lk_ppn | output | PPN_W | Physical page number of the reported entry |
| lk_perm | output | PERM_W | Permission word of the reported entry |
| ins_valid | input | 1 | Insertion request |
| ins_ready | output | 1 | Insertion can be accepted |
| ins_vpn | input | VPN_W | Tag to insert |
| ins_ppn | input | PPN_W | Physical page number to insert |
| ins_asn | input | ASN_W | Address-space number to insert |
| ins_glb | input | 1 | Global flag to insert |
| ins_perm | input | PERM_W | Permission word to insert |
| flush_all | input | 1 | Invalidate everything, reset the pointer |
| flush_proc | input | 1 | Invalidate non-global entries |
| flush_addr | input | 1 | Invalidate entries that hit for fl_vpn/fl_asn |
| fl_vpn | input | VPN_W | Page for the address flush |
| fl_asn | input | ASN_W | Address space for the address flush |
| rd_adv | input | 1 | Advance the replacement pointer |
| rd_ptr | output | IDX_W | Replacement pointer |
| rd_vld | output | 1 | Valid flag of the slot at the pointer |
| rd_vpn | output | VPN_W | Tag of the slot at the pointer |
| rd_ppn | output | PPN_W | Physical page number of the slot at the pointer |
| rd_asn | output | ASN_W | Address-space number of the slot at the pointer |
| rd_glb | output | 1 | Global flag of the slot at the pointer |
| rd_perm | output | PERM_W | Permission word of the slot at the pointer |

## Verification
The assertions assume that the insertion producer obeys the ready rule: an insertion offered during a flush is simply not accepted. They also assume that the pointer checks only follow cycles in which the pointer's own inputs act. The stimulus offers insertions during flushes on purpose and observes afterwards that neither the pointer nor the lookups changed. The stimulus creates duplicate matches only in one deliberate step that exercises the lowest-index rule. Everywhere else, tags are either distinct or differ in address space with a clear global flag.

// File: rtl/tlb_asn_pkg.sv
package tlb_asn_pkg;

  typedef enum logic [1:0] {
    FL_NONE,
    FL_ALL,
    FL_PROC,
    FL_ADDR
  } flush_op_e;

  // Fixed priority among the three flush pins.
  function automatic flush_op_e pick_flush(input logic all_i, input logic proc_i,
                                           input logic addr_i);
    if (all_i)  return FL_ALL;
    if (proc_i) return FL_PROC;
    if (addr_i) return FL_ADDR;
    return FL_NONE;
  endfunction

endpackage

// File: rtl/tlb_tag_match.sv
module tlb_tag_match #(
  parameter int N     = 48,
  parameter int VPN_W = 30,
  parameter int ASN_W = 8
) (
  input  logic                      en,
  input  logic [N-1:0]              vld,
  input  logic [N-1:0]              glb,
  input  logic [N-1:0][VPN_W-1:0]   tags,
  input  logic [N-1:0][ASN_W-1:0]   asns,
  input  logic [VPN_W-1:0]          q_vpn,
  input  logic [ASN_W-1:0]          q_asn,
  output logic [N-1:0]              match
);

  for (genvar g = 0; g < N; g++) begin : g_ent
    logic tag_eq;
    logic asn_ok;
    assign tag_eq   = (tags[g] == q_vpn);
    assign asn_ok   = glb[g] | (asns[g] == q_asn);
    assign match[g] = en & vld[g] & tag_eq & asn_ok;
  end

endmodule

// File: rtl/tlb_first_one.sv
module tlb_first_one #(
  parameter int N     = 48,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end

  assign any = |req;

endmodule

// File: rtl/tlb_rr_ptr.sv
module tlb_rr_ptr #(
  parameter int N     = 48,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  output logic [IDX_W-1:0] ptr
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ptr <= '0;
    else if (clr)   ptr <= '0;
    else if (step)  ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
  end

endmodule

// File: rtl/tlb_asn_cam.sv
module tlb_asn_cam
  import tlb_asn_pkg::*;
#(
  parameter int ENTRIES = 48,
  parameter int VPN_W   = 30,
  parameter int PPN_W   = 28,
  parameter int ASN_W   = 8,
  parameter int MODES   = 4,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int PERM_W = 2 * MODES + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASN_W-1:0]  lk_asn,
  output logic              lk_hit,
  output logic [IDX_W-1:0]  lk_idx,
  output logic [PPN_W-1:0]  lk_ppn,
  output logic [PERM_W-1:0] lk_perm,
  input  logic              ins_valid,
  output logic              ins_ready,
  input  logic [VPN_W-1:0]  ins_vpn,
  input  logic [PPN_W-1:0]  ins_ppn,
  input  logic [ASN_W-1:0]  ins_asn,
  input  logic              ins_glb,
  input  logic [PERM_W-1:0] ins_perm,
  input  logic              flush_all,
  input  logic              flush_proc,
  input  logic              flush_addr,
  input  logic [VPN_W-1:0]  fl_vpn,
  input  logic [ASN_W-1:0]  fl_asn,
  input  logic              rd_adv,
  output logic [IDX_W-1:0]  rd_ptr,
  output logic              rd_vld,
  output logic [VPN_W-1:0]  rd_vpn,
  output logic [PPN_W-1:0]  rd_ppn,
  output logic [ASN_W-1:0]  rd_asn,
  output logic              rd_glb,
  output logic [PERM_W-1:0] rd_perm
);

  // Entry storage: valid flags reset, payload written only on insertion.
  logic [ENTRIES-1:0]             vld_q;
  logic [ENTRIES-1:0]             glb_q;
  logic [ENTRIES-1:0][VPN_W-1:0]  tag_q;
  logic [ENTRIES-1:0][ASN_W-1:0]  asn_q;
  logic [ENTRIES-1:0][PPN_W-1:0]  ppn_q;
  logic [ENTRIES-1:0][PERM_W-1:0] perm_q;

  flush_op_e          fl_op;
  logic               ins_fire;
  logic [IDX_W-1:0]   ptr;
  logic [ENTRIES-1:0] lk_match;
  logic [ENTRIES-1:0] fl_match;
  logic               lk_any;
  logic [IDX_W-1:0]   lk_sel;

  assign fl_op     = pick_flush(flush_all, flush_proc, flush_addr);
  assign ins_ready = (fl_op == FL_NONE);
  assign ins_fire  = ins_valid & ins_ready;

  tlb_rr_ptr #(.N(ENTRIES), .IDX_W(IDX_W)) u_ptr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (fl_op == FL_ALL),
    .step  (ins_fire | rd_adv),
    .ptr   (ptr)
  );

  // Lookup comparators.
  tlb_tag_match #(.N(ENTRIES), .VPN_W(VPN_W), .ASN_W(ASN_W)) u_lk_match (
    .en    (lk_valid),
    .vld   (vld_q),
    .glb   (glb_q),
    .tags  (tag_q),
    .asns  (asn_q),
    .q_vpn (lk_vpn),
    .q_asn (lk_asn),
    .match (lk_match)
  );

  // Comparators for the single-address flush (same hit rule).
  tlb_tag_match #(.N(ENTRIES), .VPN_W(VPN_W), .ASN_W(ASN_W)) u_fl_match (
    .en    (1'b1),
    .vld   (vld_q),
    .glb   (glb_q),
    .tags  (tag_q),
    .asns  (asn_q),
    .q_vpn (fl_vpn),
    .q_asn (fl_asn),
    .match (fl_match)
  );

  tlb_first_one #(.N(ENTRIES), .IDX_W(IDX_W)) u_pick (
    .req (lk_match),
    .any (lk_any),
    .idx (lk_sel)
  );

  assign lk_hit  = lk_any;
  assign lk_idx  = lk_sel;
  assign lk_ppn  = ppn_q[lk_sel];
  assign lk_perm = perm_q[lk_sel];

  // Valid flags: flushes have priority over insertion.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else begin
      unique case (fl_op)
        FL_ALL:  vld_q <= '0;
        FL_PROC: vld_q <= vld_q & glb_q;
        FL_ADDR: vld_q <= vld_q & ~fl_match;
        default: if (ins_fire) vld_q[ptr] <= 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (ins_fire) begin
      glb_q[ptr]  <= ins_glb;
      tag_q[ptr]  <= ins_vpn;
      asn_q[ptr]  <= ins_asn;
      ppn_q[ptr]  <= ins_ppn;
      perm_q[ptr] <= ins_perm;
    end
  end

  // Read port at the replacement pointer.
  assign rd_ptr  = ptr;
  assign rd_vld  = vld_q[ptr];
  assign rd_vpn  = tag_q[ptr];
  assign rd_ppn  = ppn_q[ptr];
  assign rd_asn  = asn_q[ptr];
  assign rd_glb  = glb_q[ptr];
  assign rd_perm = perm_q[ptr];

endmodule

// File: rtl/tlb_asn_cam_chk.sv
module tlb_asn_cam_chk #(
  parameter int ENTRIES = 48,
  parameter int IDX_W   = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lk_valid,
  input logic               lk_hit,
  input logic               ins_valid,
  input logic               ins_ready,
  input logic               flush_all,
  input logic               flush_proc,
  input logic               flush_addr,
  input logic [IDX_W-1:0]   rd_ptr,
  input logic [ENTRIES-1:0] vld,
  input logic [ENTRIES-1:0] glb
);

  logic [IDX_W-1:0] nxt_ptr;
  assign nxt_ptr = (rd_ptr == IDX_W'(ENTRIES - 1)) ? '0 : rd_ptr + 1'b1;

  // R1
  hit_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> lk_valid);

  // R3
  insert_sets_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && ins_ready) |=> vld[$past(rd_ptr)]);

  // R4
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && ins_ready) |=> rd_ptr == $past(nxt_ptr));

  // R5
  flush_all_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> (vld == '0) && (rd_ptr == '0));

  // R6
  flush_proc_keep_glb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_proc |=> (vld & ~glb) == '0);

  // R9
  flush_blocks_ins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_all || flush_proc || flush_addr) |-> !ins_ready);

endmodule

bind tlb_asn_cam tlb_asn_cam_chk #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .lk_valid   (lk_valid),
  .lk_hit     (lk_hit),
  .ins_valid  (ins_valid),
  .ins_ready  (ins_ready),
  .flush_all  (flush_all),
  .flush_proc (flush_proc),
  .flush_addr (flush_addr),
  .rd_ptr     (rd_ptr),
  .vld        (vld_q),
  .glb        (glb_q)
);

// File: tb/tb_tlb_asn_cam.sv
module tb_tlb_asn_cam;

  localparam int E  = 6;
  localparam int VW = 8;
  localparam int PW = 8;
  localparam int AW = 4;
  localparam int M  = 4;
  localparam int IW = 3;
  localparam int QW = 2 * M + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          lk_valid = 0, lk_hit;
  logic [VW-1:0] lk_vpn = 0;
  logic [AW-1:0] lk_asn = 0;
  logic [IW-1:0] lk_idx;
  logic [PW-1:0] lk_ppn;
  logic [QW-1:0] lk_perm;
  logic          ins_valid = 0, ins_ready, ins_glb = 0;
  logic [VW-1:0] ins_vpn = 0;
  logic [PW-1:0] ins_ppn = 0;
  logic [AW-1:0] ins_asn = 0;
  logic [QW-1:0] ins_perm = 0;
  logic          flush_all = 0, flush_proc = 0, flush_addr = 0;
  logic [VW-1:0] fl_vpn = 0;
  logic [AW-1:0] fl_asn = 0;
  logic          rd_adv = 0;
  logic [IW-1:0] rd_ptr;
  logic          rd_vld, rd_glb;
  logic [VW-1:0] rd_vpn;
  logic [PW-1:0] rd_ppn;
  logic [AW-1:0] rd_asn;
  logic [QW-1:0] rd_perm;

  tlb_asn_cam #(.ENTRIES(E), .VPN_W(VW), .PPN_W(PW), .ASN_W(AW), .MODES(M)) dut (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_asn(lk_asn), .lk_hit(lk_hit),
    .lk_idx(lk_idx), .lk_ppn(lk_ppn), .lk_perm(lk_perm),
    .ins_valid(ins_valid), .ins_ready(ins_ready), .ins_vpn(ins_vpn), .ins_ppn(ins_ppn),
    .ins_asn(ins_asn), .ins_glb(ins_glb), .ins_perm(ins_perm),
    .flush_all(flush_all), .flush_proc(flush_proc), .flush_addr(flush_addr),
    .fl_vpn(fl_vpn), .fl_asn(fl_asn), .rd_adv(rd_adv),
    .rd_ptr(rd_ptr), .rd_vld(rd_vld), .rd_vpn(rd_vpn), .rd_ppn(rd_ppn),
    .rd_asn(rd_asn), .rd_glb(rd_glb), .rd_perm(rd_perm)
  );

  // Reference state
  bit            m_vld [E];
  bit            m_glb [E];
  logic [VW-1:0] m_tag [E];
  logic [AW-1:0] m_asn [E];
  logic [PW-1:0] m_ppn [E];
  logic [QW-1:0] m_perm[E];
  int            m_ptr = 0;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int ref_find(input logic [VW-1:0] v, input logic [AW-1:0] a);
    for (int i = 0; i < E; i++)
      if (m_vld[i] && m_tag[i] == v && (m_glb[i] || m_asn[i] == a)) return i;
    return -1;
  endfunction

  // Combinational lookup compare; inputs held steady in the low clock phase.
  task automatic probe(input logic [VW-1:0] v, input logic [AW-1:0] a, input string req);
    int k;
    logic [63:0] exp, act;
    lk_valid = 1; lk_vpn = v; lk_asn = a;
    #1;
    k = ref_find(v, a);
    exp = (k < 0) ? 64'd0 : {1'b1, 3'(k), m_ppn[k], m_perm[k]};
    act = lk_hit ? {lk_hit, lk_idx, lk_ppn, lk_perm} : 64'd0;
    chk(act == exp, req, act, exp);
    lk_valid = 0;
  endtask

  task automatic sweep(input string req);
    for (int v = 0; v < 128; v++)
      for (int a = 0; a < 16; a++) begin
        @(negedge clk);
        probe(VW'(v), AW'(a), req);
        probe(VW'(v), AW'(a), req);
      end
  endtask

  task automatic chk_rd(input string req);
    logic [63:0] exp, act;
    chk(rd_ptr == IW'(m_ptr), req, rd_ptr, m_ptr);
    exp = m_vld[m_ptr] ? {1'b1, m_glb[m_ptr], m_tag[m_ptr], m_asn[m_ptr], m_ppn[m_ptr], m_perm[m_ptr]} : 64'd0;
    act = rd_vld ? {rd_vld, rd_glb, rd_vpn, rd_asn, rd_ppn, rd_perm} : 64'd0;
    chk(act == exp, req, act, exp);
  endtask

  // One clock with the currently driven controls; updates the reference.
  task automatic tick();
    bit acc;
    bit hitv[E];
    acc = ins_valid && !(flush_all || flush_proc || flush_addr);
    #1;
    chk(ins_ready == !(flush_all || flush_proc || flush_addr), "R9 ready", ins_ready,
        !(flush_all || flush_proc || flush_addr));
    for (int i = 0; i < E; i++)
      hitv[i] = m_vld[i] && m_tag[i] == fl_vpn && (m_glb[i] || m_asn[i] == fl_asn);
    @(posedge clk);
    if (flush_all) begin
      for (int i = 0; i < E; i++) m_vld[i] = 0;
      m_ptr = 0;
    end else begin
      if (flush_proc) begin
        for (int i = 0; i < E; i++) if (!m_glb[i]) m_vld[i] = 0;
      end else if (flush_addr) begin
        for (int i = 0; i < E; i++) if (hitv[i]) m_vld[i] = 0;
      end else if (acc) begin
        m_vld[m_ptr] = 1; m_glb[m_ptr] = ins_glb; m_tag[m_ptr] = ins_vpn;
        m_asn[m_ptr] = ins_asn; m_ppn[m_ptr] = ins_ppn; m_perm[m_ptr] = ins_perm;
      end
      if (acc || rd_adv) m_ptr = (m_ptr + 1) % E;
    end
    @(negedge clk);
    ins_valid = 0; flush_all = 0; flush_proc = 0; flush_addr = 0; rd_adv = 0;
  endtask

  task automatic put(input int v, input int a, input bit g, input int p, input int q);
    ins_valid = 1; ins_vpn = VW'(v); ins_asn = AW'(a); ins_glb = g;
    ins_ppn = PW'(p); ins_perm = QW'(q);
    tick();
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    chk(rd_ptr == 0, "R11 ptr", rd_ptr, 0);
    chk(rd_vld == 0, "R11 valid", rd_vld, 0);
    sweep("R11 empty");

    // R3/R4 fill with wrap; R12 permission word stored as given
    for (int i = 0; i < E; i++) begin
      put(20 + i, i % 3, (i == 2 || i == 5), 8'hA0 + i, 10'h155 ^ (i * 37));
      chk(rd_ptr == IW'((i + 1) % E), "R4 advance/wrap", rd_ptr, (i + 1) % E);
    end
    sweep("R1 R12 lookup");

    // R3 overwrite slot 0
    put(20, 7, 0, 8'h77, 10'h2AA);
    sweep("R3 overwrite");

    // R8 read port and stepping
    chk_rd("R8 read");
    rd_adv = 1; tick(); chk_rd("R8 adv");
    rd_adv = 1; tick(); chk_rd("R8 adv");
    rd_adv = 1; ins_valid = 1; ins_vpn = 60; ins_asn = 3; ins_glb = 0;
    ins_ppn = 8'h60; ins_perm = 10'h0F0;
    tick(); chk_rd("R8 adv with insert");
    sweep("R8 after insert");

    // R10 lookup during flush_proc sees old state; R6
    flush_proc = 1;
    probe(21, 1, "R10 pre-flush view");
    tick();
    sweep("R6 flush_proc");

    // R9 flush_addr with competing insertion; R7 removes global entry of that tag
    put(40, 3, 0, 8'h40, 10'h011);
    put(40, 4, 0, 8'h41, 10'h022);
    flush_addr = 1; fl_vpn = 22; fl_asn = 9;
    ins_valid = 1; ins_vpn = 99; ins_asn = 1; ins_ppn = 8'h99;
    tick();
    chk_rd("R9 ptr held");
    sweep("R7 R9 flush_addr global");
    flush_addr = 1; fl_vpn = 40; fl_asn = 3;
    tick();
    sweep("R7 flush_addr asn");

    // R9 priority: all over proc over addr
    flush_proc = 1; flush_addr = 1; fl_vpn = 25; fl_asn = 2;
    tick();
    sweep("R9 proc over addr");

    // R2 deliberate duplicates
    put(50, 1, 0, 8'h51, 10'h101);
    put(50, 0, 1, 8'h52, 10'h202);
    put(50, 1, 0, 8'h53, 10'h303);
    probe(50, 1, "R2 lowest index");
    sweep("R2 duplicates");

    // R5 flush_all with other pins, R9 priority
    flush_all = 1; flush_proc = 1; rd_adv = 1; ins_valid = 1;
    tick();
    chk_rd("R5 ptr zero");
    sweep("R5 flush_all");

    // R4 refill after flush
    for (int i = 0; i < E + 2; i++) begin
      put(70 + i, i, 0, i, i);
      chk(rd_ptr == IW'((i + 1) % E), "R4 refill", rd_ptr, (i + 1) % E);
    end
    sweep("R1 R4 refill");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule